// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block holds the chip's power state and decides when it may return to full operation. Software asks for one of three low-power modes: IDLE, SLEEP or STOP. The block then gates the CPU clock, the peripheral clock and the oscillator to match that mode. It watches the wake sources and lets through only those that are legal in the present mode. Maskable interrupt lines must pass the CPU enable mask. In SLEEP and STOP they must also pass a second wake-enable mask kept on the clock-generator side. The external NMI pin wakes every mode. The watchdog NMI wakes only IDLE.

A wake from IDLE or SLEEP gives a single-cycle dispatch strobe in the next cycle. A wake from STOP first counts a programmable warm-up. It then waits for the oscillator-stable input and only after that issues the strobe. The wake-cause code records which class of event won. It holds that code until the next mode entry. The reset pin is the block's asynchronous reset. It returns the block straight to NORMAL with no warm-up, raises a register-initialise pulse and records reset as the cause.

States: RUN (NORMAL), IDLE, SLEEP, STOP, WARM (warm-up count, still reported as STOP), OSC_WAIT (clocks on, waiting for the oscillator) and DISPATCH (one cycle, strobe). Transitions:
- RUN goes to IDLE, SLEEP or STOP on an entry request.
- IDLE and SLEEP go to DISPATCH on a qualified wake.
- STOP goes to WARM on a qualified wake.
- WARM goes to OSC_WAIT when the count reaches zero.
- OSC_WAIT goes to DISPATCH when the oscillator is stable.
- DISPATCH always goes to RUN.
- An active reset pin forces RUN from any state.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and until the first clock edge after it rises, `reg_init` is 1. Reset sends the block directly to NORMAL (`mode` = 0) with all clock enables at 1, `wake_cause` = 4 and no warm-up. This holds even from STOP.
- R2: In NORMAL, `enter_req` with `enter_sel` 1, 2 or 3 moves `mode` to IDLE (1), SLEEP (2) or STOP (3) at the next edge and clears `wake_cause` to 0. `enter_sel` = 0 is ignored, and `enter_req` is ignored outside the RUN state.
- R3: `cpu_clk_en` is 0 whenever `mode` is not NORMAL. `periph_clk_en` is 1 only in NORMAL and IDLE. `osc_en` is 0 only in STOP before a wake.
- R4: In IDLE, any line with `irq[i]` & `cpu_ie[i]` set wakes the block with cause 1, whatever `wake_en` holds.
- R5: In SLEEP and STOP, an interrupt line wakes the block only if `irq[i]`, `cpu_ie[i]` and `wake_en[i]` are all 1. Otherwise the mode is kept.
- R6: `nmi_pin` wakes IDLE, SLEEP and STOP with cause 2.
- R7: `wdt_nmi` wakes IDLE with cause 3. In SLEEP and STOP it has no effect.
- R8: Events that qualify in the same cycle resolve as NMI pin (2), then watchdog (3), then interrupt (1). Cause 0 means none.
- R9: `wake_cause` keeps its value after a wake until the next accepted mode entry.
- R10: A STOP wake keeps `mode` = 3 for `warm_cnt`+1 cycles with `osc_en` = 1. `mode` then reads NORMAL with `cpu_clk_en` = 1. `dispatch` comes only in the cycle after `osc_stable` is seen high.
- R11: An IDLE or SLEEP wake gives `dispatch` = 1 for exactly one cycle, in the cycle right after the wake edge.
- R12: For an interrupt wake, `dispatch` is raised only if some `irq[i]` & `cpu_ie[i]` is still 1 during the dispatch cycle. A dropped level gets no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| enter_req | input | 1 | Request to enter a low-power mode |
| enter_sel | input | 2 | Mode to enter: 1 IDLE, 2 SLEEP, 3 STOP |
| irq | input | NIRQ | Level interrupt lines |
| cpu_ie | input | NIRQ | CPU interrupt-enable mask |
| wake_en | input | NIRQ | Clock-generator wake-enable mask |
| nmi_pin | input | 1 | External NMI |
| wdt_nmi | input | 1 | Watchdog NMI |
| osc_stable | input | 1 | Oscillator stable indication |
| warm_cnt | input | CW | Warm-up length after STOP |
| mode | output | 2 | Current mode: 0 NORMAL, 1 IDLE, 2 SLEEP, 3 STOP |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_cause | output | 3 | 0 none, 1 interrupt, 2 NMI pin, 3 watchdog, 4 reset |
| dispatch | output | 1 | Interrupt dispatch strobe |
| reg_init | output | 1 | Register-initialise pulse |

## Verification
The bench sweeps every mode against every combination of NMI pin, watchdog NMI and two-line interrupt, CPU-mask and wake-mask patterns. Each expected cause is computed from the rules.

Several errors show up as a wrong mode or cause in that sweep:
- Treating the watchdog as a SLEEP or STOP source would wake those modes wrongly.
- Ignoring the wake mask in SLEEP or STOP, or applying it in IDLE, would wake or hold the wrong cases.
- A swapped priority would report the wrong cause when sources coincide.

Directed cases cover the remaining timing rules:
- A warm-up off by one cycle shows `mode` leaving STOP a cycle early or late.
- A strobe issued before the oscillator is stable shows up as a dispatch in OSC_WAIT.
- A latched interrupt level shows up as a dispatch after the line drops.
- A reset that runs the warm-up shows up as STOP still reported after release.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_SLEEP  = 2'd2,
        MODE_STOP   = 2'd3
    } pwr_mode_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_IRQ   = 3'd1,
        CAUSE_NMI   = 3'd2,
        CAUSE_WDT   = 3'd3,
        CAUSE_RESET = 3'd4
    } wake_cause_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_SLEEP,
        ST_STOP,
        ST_WARM,
        ST_OSC_WAIT,
        ST_DISPATCH
    } pwr_state_e;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
    import pwr_wake_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input  pwr_mode_e         mode_i,
    input  logic [NIRQ-1:0]   irq_i,
    input  logic [NIRQ-1:0]   cpu_ie_i,
    input  logic [NIRQ-1:0]   wake_en_i,
    input  logic              nmi_pin_i,
    input  logic              wdt_nmi_i,
    output logic              hit_o,
    output wake_cause_e       cause_o,
    output logic              irq_live_o
);
    logic [NIRQ-1:0] line_cpu;
    logic [NIRQ-1:0] line_deep;

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        assign line_cpu[i]  = irq_i[i] & cpu_ie_i[i];
        assign line_deep[i] = line_cpu[i] & wake_en_i[i];
    end

    assign irq_live_o = |line_cpu;

    always_comb begin
        cause_o = CAUSE_NONE;
        unique case (mode_i)
            MODE_IDLE: begin
                if (nmi_pin_i)      cause_o = CAUSE_NMI;
                else if (wdt_nmi_i) cause_o = CAUSE_WDT;
                else if (|line_cpu) cause_o = CAUSE_IRQ;
            end
            MODE_SLEEP, MODE_STOP: begin
                if (nmi_pin_i)       cause_o = CAUSE_NMI;
                else if (|line_deep) cause_o = CAUSE_IRQ;
            end
            default: cause_o = CAUSE_NONE;
        endcase
    end

    assign hit_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/pwr_wake_warm.sv
module pwr_wake_warm #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          run_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int NIRQ = 2,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_req,
    input  logic [1:0]      enter_sel,
    input  logic [NIRQ-1:0] irq,
    input  logic [NIRQ-1:0] cpu_ie,
    input  logic [NIRQ-1:0] wake_en,
    input  logic            nmi_pin,
    input  logic            wdt_nmi,
    input  logic            osc_stable,
    input  logic [CW-1:0]   warm_cnt,
    output logic [1:0]      mode,
    output logic            cpu_clk_en,
    output logic            periph_clk_en,
    output logic            osc_en,
    output logic [2:0]      wake_cause,
    output logic            dispatch,
    output logic            reg_init
);
    pwr_state_e  state_q, state_d;
    wake_cause_e cause_q, cause_d;
    logic        init_q;
    pwr_mode_e   qual_mode;
    logic        wake_hit;
    wake_cause_e wake_sel;
    logic        irq_live;
    logic        warm_load;
    logic        warm_done;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  qual_mode = MODE_IDLE;
            ST_SLEEP: qual_mode = MODE_SLEEP;
            ST_STOP:  qual_mode = MODE_STOP;
            default:  qual_mode = MODE_NORMAL;
        endcase
    end

    pwr_wake_qual #(.NIRQ(NIRQ)) u_qual (
        .mode_i     (qual_mode),
        .irq_i      (irq),
        .cpu_ie_i   (cpu_ie),
        .wake_en_i  (wake_en),
        .nmi_pin_i  (nmi_pin),
        .wdt_nmi_i  (wdt_nmi),
        .hit_o      (wake_hit),
        .cause_o    (wake_sel),
        .irq_live_o (irq_live)
    );

    assign warm_load = (state_q == ST_STOP) && wake_hit;

    pwr_wake_warm #(.CW(CW)) u_warm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (warm_load),
        .load_val_i (warm_cnt),
        .run_i      (state_q == ST_WARM),
        .done_o     (warm_done)
    );

    // next-state and cause selection
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_RUN: begin
                if (enter_req) begin
                    unique case (enter_sel)
                        2'd1:    state_d = ST_IDLE;
                        2'd2:    state_d = ST_SLEEP;
                        2'd3:    state_d = ST_STOP;
                        default: state_d = ST_RUN;
                    endcase
                    if (enter_sel != 2'd0) cause_d = CAUSE_NONE;
                end
            end
            ST_IDLE, ST_SLEEP: begin
                if (wake_hit) begin
                    state_d = ST_DISPATCH;
                    cause_d = wake_sel;
                end
            end
            ST_STOP: begin
                if (wake_hit) begin
                    state_d = ST_WARM;
                    cause_d = wake_sel;
                end
            end
            ST_WARM:     if (warm_done) state_d = ST_OSC_WAIT;
            ST_OSC_WAIT: if (osc_stable) state_d = ST_DISPATCH;
            ST_DISPATCH: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= CAUSE_RESET;
            init_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            init_q  <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        mode          = MODE_NORMAL;
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        dispatch      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mode       = MODE_IDLE;
                cpu_clk_en = 1'b0;
            end
            ST_SLEEP: begin
                mode          = MODE_SLEEP;
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
            end
            ST_STOP: begin
                mode          = MODE_STOP;
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                osc_en        = 1'b0;
            end
            ST_WARM: begin
                mode          = MODE_STOP;
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
            end
            ST_DISPATCH: dispatch = (cause_q != CAUSE_IRQ) || irq_live;
            default: ;
        endcase
    end

    assign wake_cause = cause_q;
    assign reg_init   = init_q;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
    import pwr_wake_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input logic            clk,
    input logic            rst_n,
    input pwr_state_e      state_q,
    input logic            enter_req,
    input logic [1:0]      enter_sel,
    input logic [NIRQ-1:0] irq,
    input logic [NIRQ-1:0] cpu_ie,
    input logic [NIRQ-1:0] wake_en,
    input logic            nmi_pin,
    input logic [1:0]      mode,
    input logic            cpu_clk_en,
    input logic            osc_en,
    input logic [2:0]      wake_cause,
    input logic            dispatch,
    input logic            reg_init
);
    assert_init_normal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_init |-> (mode == 2'd0) && (wake_cause == 3'd4));

    assert_entry_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) && enter_req && (enter_sel != 2'd0)
        |=> (mode == $past(enter_sel)) && (wake_cause == 3'd0));

    assert_cpu_clk_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> !cpu_clk_en);

    assert_nmi_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) || (state_q == ST_SLEEP)) && nmi_pin
        |=> (wake_cause == 3'd2) && dispatch);

    assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) && !nmi_pin && !(|(irq & cpu_ie & wake_en))
        |=> (mode == 2'd2));

    assert_warm_in_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (mode == 2'd3));

    assert_dispatch_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |=> !dispatch);
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.NIRQ(NIRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .enter_req  (enter_req),
    .enter_sel  (enter_sel),
    .irq        (irq),
    .cpu_ie     (cpu_ie),
    .wake_en    (wake_en),
    .nmi_pin    (nmi_pin),
    .mode       (mode),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .wake_cause (wake_cause),
    .dispatch   (dispatch),
    .reg_init   (reg_init)
);

// File: tb/pwr_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_bench;
    localparam int NIRQ = 2;
    localparam int CW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enter_req = 1'b0;
    logic [1:0]      enter_sel = '0;
    logic [NIRQ-1:0] irq = '0;
    logic [NIRQ-1:0] cpu_ie = '0;
    logic [NIRQ-1:0] wake_en = '0;
    logic            nmi_pin = 1'b0;
    logic            wdt_nmi = 1'b0;
    logic            osc_stable = 1'b1;
    logic [CW-1:0]   warm_cnt = 8'd3;
    logic [1:0]      mode;
    logic            cpu_clk_en, periph_clk_en, osc_en;
    logic [2:0]      wake_cause;
    logic            dispatch, reg_init;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pwr_wake_ctrl #(.NIRQ(NIRQ), .CW(CW)) u_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_sel(enter_sel),
        .irq(irq), .cpu_ie(cpu_ie), .wake_en(wake_en), .nmi_pin(nmi_pin),
        .wdt_nmi(wdt_nmi), .osc_stable(osc_stable), .warm_cnt(warm_cnt),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .wake_cause(wake_cause), .dispatch(dispatch),
        .reg_init(reg_init)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic clear_inputs();
        irq = '0; cpu_ie = '0; wake_en = '0;
        nmi_pin = 1'b0; wdt_nmi = 1'b0; enter_req = 1'b0; enter_sel = 2'd0;
    endtask

    task automatic reset_dut();
        clear_inputs();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        chk("R1 init", int'(reg_init), 1);
        chk("R1 mode", int'(mode), 0);
        chk("R1 cause", int'(wake_cause), 4);
        chk("R1 clocks", int'({cpu_clk_en, periph_clk_en, osc_en}), 7);
        tick(); #1;
        chk("R1 init low", int'(reg_init), 0);
    endtask

    task automatic enter(input int m);
        enter_req = 1'b1; enter_sel = 2'(m);
        tick();
        enter_req = 1'b0; enter_sel = 2'd0;
        #1;
        chk("R2 mode", int'(mode), m);
        chk("R2 cause", int'(wake_cause), 0);
        chk("R3 cpu", int'(cpu_clk_en), 0);
        chk("R3 periph", int'(periph_clk_en), (m == 1) ? 1 : 0);
        chk("R3 osc", int'(osc_en), (m != 3) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // sweep: every mode against every event pattern
        for (int m = 1; m <= 3; m++) begin
            for (int nm = 0; nm < 2; nm++) begin
                for (int wd = 0; wd < 2; wd++) begin
                    for (int ie = 0; ie < 4; ie++) begin
                        for (int we = 0; we < 4; we++) begin
                            for (int iq = 0; iq < 4; iq++) begin
                                int qi, ec;
                                string tg;
                                reset_dut();
                                warm_cnt = 8'd3; osc_stable = 1'b1;
                                enter(m);
                                irq = 2'(iq); cpu_ie = 2'(ie); wake_en = 2'(we);
                                nmi_pin = 1'(nm); wdt_nmi = 1'(wd);
                                qi = (m == 1) ? int'((iq & ie) != 0) : int'((iq & ie & we) != 0);
                                if (nm != 0)                 ec = 2;
                                else if (wd != 0 && m == 1)  ec = 3;
                                else if (qi != 0)            ec = 1;
                                else                         ec = 0;
                                if (nm != 0 && (wd != 0 || qi != 0)) tg = "R8";
                                else if (ec == 2) tg = "R6";
                                else if (ec == 3) tg = "R7";
                                else if (ec == 1) tg = (m == 1) ? "R4" : "R5";
                                else tg = (wd != 0 && m != 1) ? "R7" : "R5";
                                tick(); #1;
                                chk({tg, " cause"}, int'(wake_cause), ec);
                                if (ec == 0) begin
                                    chk({tg, " mode kept"}, int'(mode), m);
                                    chk({tg, " no dispatch"}, int'(dispatch), 0);
                                    tick(); #1;
                                    chk({tg, " mode kept later"}, int'(mode), m);
                                end else if (m != 3) begin
                                    chk({tg, " mode"}, int'(mode), 0);
                                    chk("R11 dispatch", int'(dispatch), 1);
                                    clear_inputs();
                                    tick(); #1;
                                    chk("R11 single", int'(dispatch), 0);
                                    chk("R9 held", int'(wake_cause), ec);
                                end else begin
                                    chk("R10 warm mode", int'(mode), 3);
                                    chk("R10 osc on", int'(osc_en), 1);
                                    for (int k = 0; k < 3; k++) begin
                                        tick(); #1;
                                        chk("R10 warm mode", int'(mode), 3);
                                    end
                                    tick(); #1;
                                    chk("R10 normal", int'(mode), 0);
                                    chk("R10 cpu clk", int'(cpu_clk_en), 1);
                                    chk("R10 no early dispatch", int'(dispatch), 0);
                                    tick(); #1;
                                    chk("R10 dispatch", int'(dispatch), 1);
                                    clear_inputs();
                                    tick(); #1;
                                    chk("R9 held", int'(wake_cause), ec);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R2: select 0 ignored
        reset_dut();
        enter_req = 1'b1; enter_sel = 2'd0;
        tick(); enter_req = 1'b0; #1;
        chk("R2 sel0 mode", int'(mode), 0);
        chk("R2 sel0 cause", int'(wake_cause), 4);

        // R10: oscillator wait, warm_cnt 0; R2: entry ignored in OSC_WAIT
        reset_dut();
        warm_cnt = 8'd0; osc_stable = 1'b0;
        enter(3);
        nmi_pin = 1'b1;
        tick(); nmi_pin = 1'b0; #1;
        chk("R10 warm one cycle", int'(mode), 3);
        tick(); #1;
        chk("R10 after warm", int'(mode), 0);
        enter_req = 1'b1; enter_sel = 2'd1;
        for (int k = 0; k < 3; k++) begin
            tick(); #1;
            chk("R10 waits osc", int'(dispatch), 0);
            chk("R2 ignored in wait", int'(mode), 0);
        end
        enter_req = 1'b0; enter_sel = 2'd0;
        chk("R2 cause kept", int'(wake_cause), 2);
        osc_stable = 1'b1;
        tick(); #1;
        chk("R10 dispatch after osc", int'(dispatch), 1);

        // R12: level drops before dispatch
        reset_dut();
        enter(1);
        irq = 2'b01; cpu_ie = 2'b01;
        tick();
        irq = 2'b00; #1;
        chk("R12 cause", int'(wake_cause), 1);
        chk("R12 no dispatch", int'(dispatch), 0);
        tick(); #1;
        chk("R12 normal", int'(mode), 0);
        chk("R12 still none", int'(dispatch), 0);

        // R1: reset during STOP warm-up exits with no warm-up
        reset_dut();
        warm_cnt = 8'd20; osc_stable = 1'b1;
        enter(3);
        nmi_pin = 1'b1;
        tick(); nmi_pin = 1'b0;
        tick();
        reset_dut();
        chk("R1 no warm after reset", int'(mode), 0);
        chk("R1 cpu clk after reset", int'(cpu_clk_en), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule